// File: doc/BRIEF.md
# Banded Round-Robin Cache Victim Selector

This block chooses the way to evict when a set-associative cache brings in a new line. It holds sixteen 32-bit victim pointer registers. They are split by cache (instruction or data), by access class (normal or transient) and by a two-bit row select. Each register carries four 8-bit pointer fields, and two address bits pick one of them. A fill strobe returns the way held in the chosen field in the same cycle. On the next clock the block moves that field one step round-robin.

The step stays inside a band of ways. Each cache has one limit register that gives a first way and a last way for normal fills, and a second first/last pair for transient fills. When a pointer leaves its last way, it goes back to the first way of that band. Software sets the pointers and limits once at start-up through a simple register port. After that, hardware advances them. Only the low log2(NUM_WAYS) bits of any pointer or limit field select a way.

Top module: `rr_victim_sel`

## Requirements
- R1: Reset (rst_n low at a clock edge) clears every pointer register to zero. Both limit registers are set to 0 for the first ways and NUM_WAYS-1 for the last ways (32'h3F00_3F00 for 64 ways).
- R2: Address map. reg_addr 0x00-0x0F selects pointer register {cache, transient, row} (bit 3 set = data cache, bit 2 set = transient, bits 1:0 = row). 0x10 is the instruction-cache limit register and 0x11 is the data-cache limit register. A reg_wr write takes effect at the next edge. reg_rdata shows the addressed register combinationally. Writes to 0x12-0x1F are ignored and those addresses read zero.
- R3: fill_field selects a pointer field. 0 selects bits 31:24, 1 selects bits 23:16, 2 selects bits 15:8 and 3 selects bits 7:0.
- R4: While fill_req is high, victim_way equals the low log2(NUM_WAYS) bits of the selected field, in the same cycle.
- R5: After a fill, the selected field holds the victim plus one at the next edge, unless R6 or R8 applies. Every other field and register stays unchanged.
- R6: A fill whose victim equals the band's last way reloads the band's first way.
- R7: Limit register layout: bits 7:0 are the normal first way, 15:8 the normal last way, 23:16 the transient first way and 31:24 the transient last way. A fill uses the pair that matches fill_transient, taken from the limit register of the cache named by fill_dcache.
- R8: A fill whose victim lies outside the first-to-last band still returns that value. The field is then reloaded with the band's first way.
- R9: When a software write and a fill target the same pointer register in the same cycle, the written value is stored and the fill's update is dropped.
- R10: High bits of a pointer field above log2(NUM_WAYS) are stored and read back but do not affect the victim. A field written by a fill has those bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_req | input | 1 | Line fill strobe |
| fill_dcache | input | 1 | 1 = data cache, 0 = instruction cache |
| fill_transient | input | 1 | 1 = transient access class |
| fill_row | input | 2 | Pointer register row within the class |
| fill_field | input | 2 | Address bits that pick the pointer field |
| victim_way | output | log2(NUM_WAYS) | Way to replace, valid with fill_req |
| reg_wr | input | 1 | Software register write strobe |
| reg_addr | input | 5 | Register address for read and write |
| reg_wdata | input | 32 | Software write data |
| reg_rdata | output | 32 | Addressed register contents |

## Verification
victim_way is combinational from the stored field, so it is due in the same cycle as fill_req. The pointer step and any software write become visible on reg_rdata only after the following rising edge. The bench drives every input at the falling edge and samples victim_way and reg_rdata 1 ns later. It compares against a model that is still in its pre-edge state, and commits the model's update only after those samples. A corner such as the last-way wrap is therefore seen as the next fill's victim or as a readback one cycle later, never in the cycle of the strobe itself.

// File: rtl/rr_victim_pkg.sv
// Shared constants and field helpers for the victim selector.
// Assumes 32-bit registers made of four 8-bit pointer fields; field 0 is the
// most significant byte.
package rr_victim_pkg;
    localparam int FIELD_W = 8;
    localparam int REG_W   = 32;
    localparam int ADDR_W  = 5;
    localparam int VIDX_W  = 4;
    localparam int NUM_VIC = 16;
    localparam int NUM_LIM = 2;

    typedef logic [REG_W-1:0]   word_t;
    typedef logic [FIELD_W-1:0] field_t;

    // Bit offset of the least significant bit of a pointer field.
    function automatic int fld_lsb(input logic [1:0] s);
        return 24 - 8 * int'(s);
    endfunction

    // Extract one pointer field.
    function automatic field_t get_field(input word_t w, input logic [1:0] s);
        return w[fld_lsb(s) +: FIELD_W];
    endfunction

    // Replace one pointer field.
    function automatic word_t set_field(input word_t w, input logic [1:0] s, input field_t v);
        word_t r;
        r = w;
        r[fld_lsb(s) +: FIELD_W] = v;
        return r;
    endfunction
endpackage

// File: rtl/rr_victim_step.sv
// Computes the next round-robin pointer inside a first/last way band.
// Assumes the pointer and limits are already cut to the way-index width.
// A pointer outside the band, or at its last way, goes to the first way.
module rr_victim_step #(
    parameter int WAY_W = 6
) (
    input  logic [WAY_W-1:0] cur_way,
    input  logic [WAY_W-1:0] band_first,
    input  logic [WAY_W-1:0] band_last,
    output logic [WAY_W-1:0] next_way
);
    logic in_band;

    // Decide whether the pointer lies inside the band and step it.
    always_comb begin
        in_band = (cur_way >= band_first) && (cur_way <= band_last);
        if (!in_band || cur_way == band_last)
            next_way = band_first;
        else
            next_way = cur_way + WAY_W'(1);
    end

    // Check the stepped value against the band rules.
    always_comb begin
        if (band_first <= band_last) begin
            // R6
            if (cur_way == band_last)
                last_wrap_chk: assert (next_way == band_first);
            // R8
            if (cur_way < band_first || cur_way > band_last)
                out_of_band_chk: assert (next_way == band_first);
            // R5
            band_keep_chk: assert (next_way >= band_first && next_way <= band_last);
        end
    end
endmodule

// File: rtl/rr_victim_bank.sv
// Storage for the sixteen pointer registers and two limit registers, with
// the software read/write decode and the hardware field update.
// Assumes a software write to a register beats a fill update to it.
module rr_victim_bank
    import rr_victim_pkg::*;
#(
    parameter int NUM_WAYS = 64,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wr_data,
    output word_t             rd_data,
    input  logic [VIDX_W-1:0] sel_idx,
    input  logic [1:0]        sel_fld,
    input  logic              sel_transient,
    input  logic              upd_en,
    input  field_t            upd_val,
    output logic [WAY_W-1:0]  cur_way,
    output logic [WAY_W-1:0]  band_first,
    output logic [WAY_W-1:0]  band_last
);
    localparam field_t TOP_WAY = FIELD_W'(NUM_WAYS - 1);
    localparam word_t  LIM_RST = {TOP_WAY, 8'h00, TOP_WAY, 8'h00};

    word_t vic_q [NUM_VIC];
    word_t lim_q [NUM_LIM];
    logic [NUM_VIC-1:0] vic_hit;
    logic [NUM_LIM-1:0] lim_hit;
    word_t  lim_sel;
    field_t fld_sel;
    int     lim_base;

    // Decode software write targets.
    always_comb begin
        for (int i = 0; i < NUM_VIC; i++)
            vic_hit[i] = wr_en && (addr == {1'b0, VIDX_W'(i)});
        for (int c = 0; c < NUM_LIM; c++)
            lim_hit[c] = wr_en && (addr == {4'b1000, 1'(c)});
    end

    // Register update: reset, software write, then fill step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_VIC; i++) vic_q[i] <= '0;
            for (int c = 0; c < NUM_LIM; c++) lim_q[c] <= LIM_RST;
        end else begin
            for (int i = 0; i < NUM_VIC; i++) begin
                if (vic_hit[i])
                    vic_q[i] <= wr_data;
                else if (upd_en && sel_idx == VIDX_W'(i))
                    vic_q[i] <= set_field(vic_q[i], sel_fld, upd_val);
            end
            for (int c = 0; c < NUM_LIM; c++)
                if (lim_hit[c]) lim_q[c] <= wr_data;
        end
    end

    // Software read mux.
    always_comb begin
        if (!addr[4])
            rd_data = vic_q[addr[3:0]];
        else if (addr[3:1] == 3'b000)
            rd_data = lim_q[addr[0]];
        else
            rd_data = '0;
    end

    // Select the pointer field and the band for the current fill.
    always_comb begin
        fld_sel    = get_field(vic_q[sel_idx], sel_fld);
        cur_way    = fld_sel[WAY_W-1:0];
        lim_sel    = lim_q[sel_idx[3]];
        lim_base   = sel_transient ? 16 : 0;
        band_first = lim_sel[lim_base +: WAY_W];
        band_last  = lim_sel[lim_base + 8 +: WAY_W];
    end

    // R2
    sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr[4]) |=> vic_q[$past(addr[3:0])] == $past(wr_data));

    // R5
    fill_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !vic_hit[sel_idx]) |=>
            get_field(vic_q[$past(sel_idx)], $past(sel_fld)) == $past(upd_val));

    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && vic_hit[sel_idx]) |=> vic_q[$past(sel_idx)] == $past(wr_data));

    for (genvar g = 0; g < NUM_VIC; g++) begin : g_hold
        // R5
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!vic_hit[g] && !(upd_en && sel_idx == VIDX_W'(g))) |=> $stable(vic_q[g]));
    end
endmodule

// File: rtl/rr_victim_sel.sv
// Top of the banded round-robin victim selector. Returns the victim way in
// the strobe cycle and steps the selected pointer field at the next edge.
// Assumes NUM_WAYS is a power of two no larger than 256.
module rr_victim_sel
    import rr_victim_pkg::*;
#(
    parameter int NUM_WAYS = 64,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_req,
    input  logic              fill_dcache,
    input  logic              fill_transient,
    input  logic [1:0]        fill_row,
    input  logic [1:0]        fill_field,
    output logic [WAY_W-1:0]  victim_way,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);
    logic [VIDX_W-1:0] sel_idx;
    logic [WAY_W-1:0]  cur_way, band_first, band_last, next_way;
    field_t            upd_val;

    // Form the register index and the widened update value.
    always_comb begin
        sel_idx = {fill_dcache, fill_transient, fill_row};
        upd_val = FIELD_W'(next_way);
    end

    rr_victim_bank #(.NUM_WAYS(NUM_WAYS)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr),
        .addr         (reg_addr),
        .wr_data      (reg_wdata),
        .rd_data      (reg_rdata),
        .sel_idx      (sel_idx),
        .sel_fld      (fill_field),
        .sel_transient(fill_transient),
        .upd_en       (fill_req),
        .upd_val      (upd_val),
        .cur_way      (cur_way),
        .band_first   (band_first),
        .band_last    (band_last)
    );

    rr_victim_step #(.WAY_W(WAY_W)) u_step (
        .cur_way   (cur_way),
        .band_first(band_first),
        .band_last (band_last),
        .next_way  (next_way)
    );

    assign victim_way = cur_way;
endmodule

// File: tb/rr_victim_sel_bench.sv
module rr_victim_sel_bench;
    localparam int W = 64;
    localparam int M = W - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fill_req = 0, fill_dcache = 0, fill_transient = 0;
    logic [1:0] fill_row = 0, fill_field = 0;
    logic [5:0] victim_way;
    logic reg_wr = 0;
    logic [4:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;

    logic [31:0] m_vic [16];
    logic [31:0] m_lim [2];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rr_victim_sel #(.NUM_WAYS(W)) u_rr_victim_sel (
        .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .fill_dcache(fill_dcache),
        .fill_transient(fill_transient), .fill_row(fill_row), .fill_field(fill_field),
        .victim_way(victim_way), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] fget(input logic [31:0] w, input logic [1:0] s);
        case (s)
            2'd0: return w[31:24];
            2'd1: return w[23:16];
            2'd2: return w[15:8];
            default: return w[7:0];
        endcase
    endfunction

    function automatic logic [31:0] fput(input logic [31:0] w, input logic [1:0] s, input logic [7:0] v);
        logic [31:0] r = w;
        case (s)
            2'd0: r[31:24] = v;
            2'd1: r[23:16] = v;
            2'd2: r[15:8]  = v;
            default: r[7:0] = v;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        if (a[4] == 1'b0) return m_vic[a[3:0]];
        if (a[3:1] == 3'b000) return m_lim[a[0]];
        return 32'h0;
    endfunction

    function automatic int stepped(input int cur, input int f, input int l);
        if (cur < f || cur > l || cur == l) return f;
        return cur + 1;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic f, input logic dc, input logic tr, input logic [1:0] row,
                       input logic [1:0] sel, input logic w, input logic [4:0] a,
                       input logic [31:0] d, input string tag);
        int idx, cur, fr, la;
        logic [31:0] lw;
        @(negedge clk);
        fill_req = f; fill_dcache = dc; fill_transient = tr; fill_row = row; fill_field = sel;
        reg_wr = w; reg_addr = a; reg_wdata = d;
        #1;
        idx = {dc, tr, row};
        cur = int'(fget(m_vic[idx], sel)) & M;
        lw  = m_lim[dc];
        fr  = tr ? (int'(lw[23:16]) & M) : (int'(lw[7:0]) & M);
        la  = tr ? (int'(lw[31:24]) & M) : (int'(lw[15:8]) & M);
        if (f) check(32'(victim_way), 32'(cur), tag);
        if (!w) check(reg_rdata, exp_read(a), tag);
        if (f && !(w && a == 5'(idx)))
            m_vic[idx] = fput(m_vic[idx], sel, 8'(stepped(cur, fr, la)));
        if (w) begin
            if (!a[4]) m_vic[a[3:0]] = d;
            else if (a[3:1] == 3'b000) m_lim[a[0]] = d;
        end
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        cyc(0, 0, 0, 0, 0, 0, a, 0, tag);
    endtask

    task automatic wrr(input logic [4:0] a, input logic [31:0] d, input string tag);
        cyc(0, 0, 0, 0, 0, 1, a, d, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'h5EED_0042);
        for (int i = 0; i < 16; i++) m_vic[i] = 32'h0;
        for (int c = 0; c < 2; c++) m_lim[c] = {8'(M), 8'h00, 8'(M), 8'h00};
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state on every address
        for (int a = 0; a < 32; a++) rd(5'(a), "R1");

        // R2: write, read back, ignored address
        wrr(5'h0B, 32'hDEAD_BEEF, "R2");
        rd(5'h0B, "R2");
        wrr(5'h17, 32'hFFFF_FFFF, "R2");
        rd(5'h17, "R2");

        // R3 / R10: field order and unused high bits
        wrr(5'h00, 32'h1234_5678, "R3");
        cyc(1, 0, 0, 0, 0, 0, 5'h00, 0, "R3");
        cyc(1, 0, 0, 0, 1, 0, 5'h00, 0, "R3");
        cyc(1, 0, 0, 0, 2, 0, 5'h00, 0, "R10");
        cyc(1, 0, 0, 0, 3, 0, 5'h00, 0, "R10");
        rd(5'h00, "R5");

        // R6: narrow normal band 4..6 on the instruction cache
        wrr(5'h10, 32'h0301_0604, "R7");
        wrr(5'h00, 32'h0600_0000, "R6");
        for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 0, 0, 5'h00, 0, "R6");

        // R7: transient band 1..3 on same cache
        wrr(5'h04, 32'h0300_0000, "R7");
        for (int k = 0; k < 4; k++) cyc(1, 0, 1, 0, 0, 0, 5'h04, 0, "R7");

        // R8: pointer outside band
        wrr(5'h00, 32'h3F00_0000, "R8");
        cyc(1, 0, 0, 0, 0, 0, 5'h00, 0, "R8");
        cyc(1, 0, 0, 0, 0, 0, 5'h00, 0, "R8");

        // R10: high bits ignored, cleared on update
        wrr(5'h00, 32'hC500_0000, "R10");
        cyc(1, 0, 0, 0, 0, 0, 5'h00, 0, "R10");
        rd(5'h00, "R10");

        // R9: write and fill on the same register
        cyc(1, 0, 0, 0, 0, 1, 5'h00, 32'hAABB_CCDD, "R9");
        rd(5'h00, "R9");

        // R4 / R5: data cache, default band, other fields untouched
        wrr(5'h0D, 32'h0102_0304, "R4");
        cyc(1, 1, 1, 1, 2, 0, 5'h0D, 0, "R4");
        rd(5'h0D, "R5");

        // Random mix checked against the model
        for (int n = 0; n < 4000; n++) begin
            logic f, w;
            logic [4:0] a;
            logic [31:0] d;
            f = ($urandom_range(0, 9) < 6);
            w = ($urandom_range(0, 19) < 3);
            a = 5'($urandom_range(0, 19));
            d = $urandom;
            if (a[4] && $urandom_range(0, 3) != 0)
                d = {8'($urandom_range(0, M)), 8'($urandom_range(0, 8)),
                     8'($urandom_range(0, M)), 8'($urandom_range(0, 8))};
            cyc(f, 1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), w, a, d,
                "R4 R5 R6 R7 R8 random");
        end

        @(negedge clk);
        fill_req = 0; reg_wr = 0;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule